// File: doc/BRIEF.md
# Configuration Port FIFO Controller

This peripheral connects a 32-bit register bus to a 32-bit configuration data port. The host loads configuration words into a deep outbound FIFO. A command bit then streams those words to the port. For readback, the host writes a word count and issues a second command. That many words are then pulled from the port into a smaller inbound FIFO, and the host pops them through a register.

Both port directions use valid/ready. On the outbound side, a word moves on a clock edge where `cp_out_valid` and `cp_out_ready` are both high. While ready is low, valid stays high and the data does not change. On the inbound side, `cp_in_ready` is high only during a readback that still needs words and only while the inbound FIFO has room. The source may hold `cp_in_valid` high as long as it likes.

The host sees:
- free and used entry counts for the two FIFOs;
- a status word whose bit 0 is high when the block is idle, with four port condition inputs mirrored into it;
- a soft reset bit and a FIFO clear bit;
- an interrupt block with per-bit toggle-on-write status, per-bit enables and a master enable.

Top module: `cfg_port_fifo_ctrl`

## Requirements
- R1: After reset, the status word (0x110) reads 0x1F, the outbound free count (0x114) equals the outbound depth, the inbound used count (0x118) is 0, the interrupt status (0x20) is 0 and `irq` is low.
- R2: A bus write to 0x100 pushes the data into the outbound FIFO and lowers the free count by one. A write made while that FIFO is full is dropped: the count stays 0 and the word never reaches the port.
- R3: Writing control (0x10C) with bit 0 set while idle streams the stored words to the port in push order under valid/ready. Valid and data hold while ready is low. Status bit 0 reads 0 until the cycle after the last word is taken.
- R4: The bit 0 command given with an empty outbound FIFO leaves status bit 0 at 1 and sends nothing.
- R5: Control bit 1 moves exactly N words from the port into the inbound FIFO, where N is bits 11:0 of the size register (0x108). Status bit 0 is 0 until the N-th word is taken. N = 0 sends nothing and stays idle.
- R6: During a readback, `cp_in_ready` is low whenever the inbound FIFO is full and rises again once a word is popped. The used count (0x118) reports the stored words.
- R7: A bus read of 0x104 returns the oldest inbound word and removes it. A read of that address while the FIFO is empty leaves the used count unchanged.
- R8: Commands written while a transfer is in progress are ignored.
- R9: Control bit 2 empties both FIFOs: the free count returns to the depth and the used count to 0.
- R10: Control bit 3 holds the block in soft reset until a later control write clears it. Control reads back bit 3 while it is set. Size, interrupt enables and master enable read 0 and both FIFOs are empty. Pushes made during soft reset are dropped.
- R11: Status bits 5, 6, 7 and 8 mirror `st_abort`, `st_rip`, `st_align` and `st_cfgerr`. Bits 1 to 4 read 1 and bits 31:9 read 0.
- R12: Interrupt status bit k (0x20) sets when its source rises. The sources are:
  - k=0: outbound FIFO at least half full;
  - k=1: inbound FIFO at least half full;
  - k=2: outbound FIFO empty;
  - k=3: inbound FIFO full.
  Writing 1 to bit k flips it. `irq` is high only when bit 31 of 0x1C is set and some status bit is also set in the enable register (0x28).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the inbound FIFO at 0x104) |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| cp_out_valid | output | 1 | Outbound word valid |
| cp_out_ready | input | 1 | Port accepts the outbound word |
| cp_out_data | output | 32 | Outbound word |
| cp_in_valid | input | 1 | Port offers a readback word |
| cp_in_ready | output | 1 | Block accepts the readback word |
| cp_in_data | input | 32 | Readback word |
| st_abort | input | 1 | Port abort condition |
| st_rip | input | 1 | Port readback-in-progress condition |
| st_align | input | 1 | Port alignment condition |
| st_cfgerr | input | 1 | Port configuration error condition |
| irq | output | 1 | Interrupt request |

## Verification
Each FIFO can be touched by the host bus and by the port in the same clock edge. A host push can coincide with the port taking the last queued word. A host pop can coincide with the port delivering a readback word. The bench provokes both:
- it keeps pushing while a stalled drain runs;
- it pops the inbound FIFO while a readback larger than that FIFO is still filling.
Each run is judged by the full word sequence seen at the port or popped by the host, which must match the arithmetic pattern exactly, plus the final free and used counts.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam logic [11:0] OFS_GIE   = 12'h01C;
  localparam logic [11:0] OFS_ISR   = 12'h020;
  localparam logic [11:0] OFS_IER   = 12'h028;
  localparam logic [11:0] OFS_WFIFO = 12'h100;
  localparam logic [11:0] OFS_RFIFO = 12'h104;
  localparam logic [11:0] OFS_SIZE  = 12'h108;
  localparam logic [11:0] OFS_CTRL  = 12'h10C;
  localparam logic [11:0] OFS_STAT  = 12'h110;
  localparam logic [11:0] OFS_WVAC  = 12'h114;
  localparam logic [11:0] OFS_ROCC  = 12'h118;

  localparam int CB_DRAIN = 0;
  localparam int CB_FILL  = 1;
  localparam int CB_FLUSH = 2;
  localparam int CB_SRST  = 3;

  localparam int IRQ_N = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_FILL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cfp_sync_fifo.sv
module cfp_sync_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/cfp_seq.sv
module cfp_seq #(
  parameter int SZW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           srst,
  input  logic           cmd_drain,
  input  logic           cmd_fill,
  input  logic [SZW-1:0] fill_len,
  input  logic           wf_empty,
  input  logic           wf_last,
  input  logic           wf_push,
  input  logic           rf_full,
  input  logic           out_ready,
  input  logic           in_valid,
  output logic           out_valid,
  output logic           out_pop,
  output logic           in_ready,
  output logic           in_push,
  output logic           busy
);
  import cfp_pkg::*;

  seq_state_e     state_q;
  logic [SZW-1:0] remain_q;

  always_comb begin
    out_valid = (state_q == SEQ_DRAIN) && !wf_empty;
    out_pop   = out_valid && out_ready;
    in_ready  = (state_q == SEQ_FILL) && !rf_full;
    in_push   = in_ready && in_valid;
    busy      = (state_q != SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      remain_q <= '0;
    end else if (srst) begin
      state_q  <= SEQ_IDLE;
      remain_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cmd_drain && !wf_empty) begin
            state_q <= SEQ_DRAIN;
          end else if (cmd_fill && fill_len != '0) begin
            state_q  <= SEQ_FILL;
            remain_q <= fill_len;
          end
        end
        SEQ_DRAIN: begin
          // a push landing with the final pop keeps the drain alive
          if (wf_empty || (out_pop && wf_last && !wf_push)) state_q <= SEQ_IDLE;
        end
        SEQ_FILL: begin
          if (in_push) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == SZW'(1)) state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfp_irq.sv
module cfp_irq #(
  parameter int         N       = 4,
  parameter logic [3:0] SRC_RST = 4'b0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [N-1:0] src,
  input  logic         tog_we,
  input  logic [N-1:0] tog_mask,
  input  logic [N-1:0] ier,
  input  logic         gie,
  output logic [N-1:0] isr,
  output logic         irq
);
  logic [N-1:0] prev_q, isr_q;
  logic [N-1:0] flip;

  assign flip = tog_we ? tog_mask : '0;
  assign isr  = isr_q;
  assign irq  = gie && |(isr_q & ier);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      prev_q <= SRC_RST[N-1:0];
    end else if (srst) begin
      isr_q  <= '0;
      prev_q <= SRC_RST[N-1:0];
    end else begin
      prev_q <= src;
      isr_q  <= (isr_q ^ flip) | (src & ~prev_q);
    end
  end
endmodule

// File: rtl/cfg_port_fifo_ctrl.sv
module cfg_port_fifo_ctrl #(
  parameter int DW       = 32,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  parameter int SZW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          cp_out_valid,
  input  logic          cp_out_ready,
  output logic [DW-1:0] cp_out_data,
  input  logic          cp_in_valid,
  output logic          cp_in_ready,
  input  logic [DW-1:0] cp_in_data,
  input  logic          st_abort,
  input  logic          st_rip,
  input  logic          st_align,
  input  logic          st_cfgerr,
  output logic          irq
);
  import cfp_pkg::*;

  localparam int WCW = $clog2(WR_DEPTH+1);
  localparam int RCW = $clog2(RD_DEPTH+1);

  logic             sw_rst_q, gie_q;
  logic [IRQ_N-1:0] ier_q;
  logic [SZW-1:0]   size_q;

  logic             ctrl_we, srst_req, cmd_ok;
  logic             cmd_drain, cmd_fill, flush_now;
  logic             wf_push_req, wf_push_ok, rf_pop_req;
  logic             wf_full, wf_empty, rf_full, rf_empty;
  logic [WCW-1:0]   wf_count;
  logic [RCW-1:0]   rf_count;
  logic [DW-1:0]    rf_head;
  logic             out_pop, in_push, seq_busy;
  logic [IRQ_N-1:0] irq_src, isr;
  logic [WCW-1:0]   wf_vac;

  // bus decode
  assign ctrl_we     = reg_wr_en && (reg_addr == OFS_CTRL);
  assign srst_req    = ctrl_we && reg_wdata[CB_SRST];
  assign cmd_ok      = ctrl_we && !reg_wdata[CB_SRST] && !sw_rst_q;
  assign cmd_drain   = cmd_ok && reg_wdata[CB_DRAIN];
  assign cmd_fill    = cmd_ok && reg_wdata[CB_FILL];
  assign flush_now   = cmd_ok && reg_wdata[CB_FLUSH];
  assign wf_push_req = reg_wr_en && (reg_addr == OFS_WFIFO) && !sw_rst_q;
  assign wf_push_ok  = wf_push_req && !wf_full;
  assign rf_pop_req  = reg_rd_en && (reg_addr == OFS_RFIFO) && !sw_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_rst_q <= 1'b0;
    else if (ctrl_we) sw_rst_q <= reg_wdata[CB_SRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      ier_q  <= '0;
      size_q <= '0;
    end else if (sw_rst_q) begin
      gie_q  <= 1'b0;
      ier_q  <= '0;
      size_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == OFS_GIE)  gie_q  <= reg_wdata[31];
      if (reg_addr == OFS_IER)  ier_q  <= reg_wdata[IRQ_N-1:0];
      if (reg_addr == OFS_SIZE) size_q <= reg_wdata[SZW-1:0];
    end
  end

  cfp_sync_fifo #(.DW(DW), .DEPTH(WR_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .clr(flush_now || sw_rst_q),
    .push(wf_push_req), .wdata(reg_wdata), .pop(out_pop),
    .rdata(cp_out_data), .full(wf_full), .empty(wf_empty), .count(wf_count)
  );

  cfp_sync_fifo #(.DW(DW), .DEPTH(RD_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .clr(flush_now || sw_rst_q),
    .push(in_push), .wdata(cp_in_data), .pop(rf_pop_req),
    .rdata(rf_head), .full(rf_full), .empty(rf_empty), .count(rf_count)
  );

  cfp_seq #(.SZW(SZW)) u_seq (
    .clk(clk), .rst_n(rst_n), .srst(sw_rst_q),
    .cmd_drain(cmd_drain), .cmd_fill(cmd_fill), .fill_len(size_q),
    .wf_empty(wf_empty), .wf_last(wf_count == WCW'(1)), .wf_push(wf_push_ok),
    .rf_full(rf_full), .out_ready(cp_out_ready), .in_valid(cp_in_valid),
    .out_valid(cp_out_valid), .out_pop(out_pop), .in_ready(cp_in_ready),
    .in_push(in_push), .busy(seq_busy)
  );

  assign irq_src[0] = (wf_count >= WCW'(WR_DEPTH/2));
  assign irq_src[1] = (rf_count >= RCW'(RD_DEPTH/2));
  assign irq_src[2] = wf_empty;
  assign irq_src[3] = rf_full;

  cfp_irq #(.N(IRQ_N), .SRC_RST(4'b0100)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(sw_rst_q), .src(irq_src),
    .tog_we(reg_wr_en && (reg_addr == OFS_ISR) && !sw_rst_q),
    .tog_mask(reg_wdata[IRQ_N-1:0]), .ier(ier_q), .gie(gie_q),
    .isr(isr), .irq(irq)
  );

  assign wf_vac = WCW'(WR_DEPTH) - wf_count;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_GIE:   reg_rdata = {gie_q, 31'b0};
      OFS_ISR:   reg_rdata = 32'(isr);
      OFS_IER:   reg_rdata = 32'(ier_q);
      OFS_RFIFO: reg_rdata = rf_empty ? '0 : 32'(rf_head);
      OFS_SIZE:  reg_rdata = 32'(size_q);
      OFS_CTRL:  reg_rdata = {28'b0, sw_rst_q, 3'b000};
      OFS_STAT:  reg_rdata = {23'b0, st_cfgerr, st_align, st_rip, st_abort,
                              4'b1111, !seq_busy};
      OFS_WVAC:  reg_rdata = 32'(wf_vac);
      OFS_ROCC:  reg_rdata = 32'(rf_count);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int DW       = 32,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sw_rst_q,
  input logic                         srst_req,
  input logic                         flush_now,
  input logic                         cp_out_valid,
  input logic                         cp_out_ready,
  input logic [DW-1:0]                cp_out_data,
  input logic                         cp_in_ready,
  input logic                         seq_busy,
  input logic [$clog2(WR_DEPTH+1)-1:0] wf_count,
  input logic [$clog2(RD_DEPTH+1)-1:0] rf_count,
  input logic                         irq,
  input logic                         gie_q
);
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_out_valid && !cp_out_ready && !flush_now && !srst_req && !sw_rst_q)
      |=> (cp_out_valid && $stable(cp_out_data)));

  p_fill_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_in_ready |-> seq_busy);

  p_fill_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_in_ready |-> (rf_count < RD_DEPTH));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_count <= WR_DEPTH) && (rf_count <= RD_DEPTH));

  p_srst_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_q |=> (wf_count == '0 && rf_count == '0 && !seq_busy));

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
endmodule

bind cfg_port_fifo_ctrl cfp_checker #(
  .DW(DW), .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst_q(sw_rst_q), .srst_req(srst_req),
  .flush_now(flush_now), .cp_out_valid(cp_out_valid),
  .cp_out_ready(cp_out_ready), .cp_out_data(cp_out_data),
  .cp_in_ready(cp_in_ready), .seq_busy(seq_busy), .wf_count(wf_count),
  .rf_count(rf_count), .irq(irq), .gie_q(gie_q)
);

// File: tb/cfg_port_fifo_ctrl_bench.sv
module cfg_port_fifo_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 8;
  localparam int RDP = 4;

  localparam logic [11:0] A_GIE = 12'h01C, A_ISR = 12'h020, A_IER = 12'h028,
    A_WF = 12'h100, A_RF = 12'h104, A_SZ = 12'h108, A_CTRL = 12'h10C,
    A_STAT = 12'h110, A_WVAC = 12'h114, A_ROCC = 12'h118;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cp_out_valid, cp_out_ready = 0;
  logic [31:0] cp_out_data;
  logic cp_in_valid = 0, cp_in_ready;
  logic [31:0] cp_in_data = '0;
  logic st_abort = 0, st_rip = 0, st_align = 0, st_cfgerr = 0;
  logic irq;

  int checks = 0, failures = 0;
  int ready_mode = 0, cyc = 0;
  int in_idx = 0;
  logic in_fire = 0;
  logic [31:0] out_log [64];
  int out_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_fifo_ctrl #(.DW(32), .WR_DEPTH(WD), .RD_DEPTH(RDP), .SZW(12)) u_cfg_port_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cp_out_valid(cp_out_valid), .cp_out_ready(cp_out_ready), .cp_out_data(cp_out_data),
    .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready), .cp_in_data(cp_in_data),
    .st_abort(st_abort), .st_rip(st_rip), .st_align(st_align), .st_cfgerr(st_cfgerr),
    .irq(irq)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hA500_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  // port-side models: source and sink
  initial begin
    forever begin
      @(negedge clk);
      if (in_fire) in_idx++;
      cp_in_data = pat(in_idx);
      cp_out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : ((cyc % 3) != 2);
      cyc++;
      #2;
      in_fire = cp_in_valid && cp_in_ready;
      if (cp_out_valid && cp_out_ready && out_n < 64) begin
        out_log[out_n] = cp_out_data;
        out_n++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 0;
  endtask

  task automatic wait_done(string req);
    logic [31:0] s;
    s = '0;
    for (int t = 0; t < 300; t++) begin
      reg_rd(A_STAT, s);
      if (s[0]) break;
    end
    chk(req, 32'(s[0]), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_w [16];
    int base, got, keep, lim;
    cp_in_valid = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_rd(A_STAT, v); chk("R1 status", v, 32'h1F);
    reg_rd(A_WVAC, v); chk("R1 vacancy", v, WD);
    reg_rd(A_ROCC, v); chk("R1 occupancy", v, 0);
    reg_rd(A_ISR, v);  chk("R1 isr", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R11 status mirrors
    st_abort = 1; st_align = 1;
    reg_rd(A_STAT, v); chk("R11 abort+align", v, 32'h0BF);
    st_abort = 0; st_align = 0; st_rip = 1; st_cfgerr = 1;
    reg_rd(A_STAT, v); chk("R11 rip+cfgerr", v, 32'h15F);
    st_rip = 0; st_cfgerr = 0;

    // R2/R3/R4 sweep of push counts including overflow
    for (int n = 0; n <= WD + 2; n++) begin
      ready_mode = (n % 3 == 1) ? 2 : 0;
      for (int k = 0; k < n; k++) begin
        reg_wr(A_WF, 32'h1000_0000 + 32'(n * 16 + k));
        if (k < WD) exp_w[k] = 32'h1000_0000 + 32'(n * 16 + k);
        reg_rd(A_WVAC, v);
        chk("R2 vacancy", v, (k + 1 < WD) ? 32'(WD - k - 1) : 32'd0);
      end
      out_n = 0;
      reg_wr(A_CTRL, 32'h1);
      if (n == 0) begin
        reg_rd(A_STAT, v); chk("R4 done on empty", 32'(v[0]), 1);
      end
      wait_done("R3 drain done");
      keep = (n < WD) ? n : WD;
      chk("R2 dropped words absent", out_n, keep);
      for (int k = 0; k < keep; k++) chk("R3 order", out_log[k], exp_w[k]);
      reg_rd(A_WVAC, v); chk("R3 vacancy after", v, WD);
    end

    // R3 concurrency: pushes during a stalled drain
    ready_mode = 1; out_n = 0;
    reg_wr(A_WF, 32'hB0); reg_wr(A_WF, 32'hB1);
    reg_wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    #2 chk("R3 valid held", 32'(cp_out_valid), 1);
    chk("R3 data held", cp_out_data, 32'hB0);
    reg_wr(A_WF, 32'hB2);
    ready_mode = 2;
    reg_wr(A_WF, 32'hB3);
    wait_done("R3 drain with pushes");
    chk("R3 concurrent count", out_n, 4);
    for (int k = 0; k < 4; k++) chk("R3 concurrent order", out_log[k], 32'hB0 + k);
    ready_mode = 0;

    // R5/R6/R7 readback sweep
    for (int sz = 0; sz <= 7; sz++) begin
      reg_wr(A_SZ, 32'(sz));
      base = in_idx;
      reg_wr(A_CTRL, 32'h2);
      if (sz == 0) begin
        reg_rd(A_STAT, v); chk("R5 zero size idle", 32'(v[0]), 1);
      end
      repeat (12) @(negedge clk);
      lim = (sz < RDP) ? sz : RDP;
      reg_rd(A_ROCC, v); chk("R6 occupancy", v, lim);
      #2 chk("R6 ready low", 32'(cp_in_ready), 0);
      if (sz > RDP) begin
        reg_rd(A_STAT, v); chk("R5 busy while stalled", 32'(v[0]), 0);
      end
      got = 0;
      for (int t = 0; t < 200 && got < sz; t++) begin
        reg_rd(A_ROCC, v);
        if (v != 0) begin
          reg_rd(A_RF, v);
          chk("R7 pop value", v, pat(base + got));
          got++;
        end
      end
      wait_done("R5 fill done");
      chk("R5 exact count", 32'(in_idx - base), 32'(sz));
      reg_rd(A_ROCC, v); chk("R7 drained", v, 0);
    end
    reg_rd(A_RF, v);
    reg_rd(A_ROCC, v); chk("R7 empty pop no effect", v, 0);

    // R8 command while busy ignored
    ready_mode = 1; out_n = 0;
    reg_wr(A_WF, 32'hC0); reg_wr(A_WF, 32'hC1); reg_wr(A_WF, 32'hC2);
    reg_wr(A_CTRL, 32'h1);
    reg_wr(A_SZ, 32'h2);
    reg_wr(A_CTRL, 32'h2);
    repeat (6) @(negedge clk);
    #2 chk("R8 ready stays low", 32'(cp_in_ready), 0);
    reg_rd(A_ROCC, v); chk("R8 no readback", v, 0);
    reg_rd(A_STAT, v); chk("R8 still busy", 32'(v[0]), 0);
    ready_mode = 0;
    wait_done("R8 drain done");
    chk("R8 drain count", out_n, 3);
    reg_rd(A_ROCC, v); chk("R8 occupancy after", v, 0);

    // R9 flush
    for (int k = 0; k < 5; k++) reg_wr(A_WF, 32'(k));
    reg_wr(A_SZ, 32'h3); reg_wr(A_CTRL, 32'h2);
    wait_done("R9 fill");
    reg_rd(A_ROCC, v); chk("R9 pre occupancy", v, 3);
    reg_wr(A_CTRL, 32'h4);
    reg_rd(A_WVAC, v); chk("R9 vacancy", v, WD);
    reg_rd(A_ROCC, v); chk("R9 occupancy", v, 0);

    // R12 interrupts
    reg_wr(A_CTRL, 32'h8); reg_wr(A_CTRL, 32'h0);
    reg_wr(A_IER, 32'h1); reg_wr(A_GIE, 32'h8000_0000);
    for (int k = 0; k < WD / 2 - 1; k++) reg_wr(A_WF, 32'(k));
    reg_rd(A_ISR, v); chk("R12 below half", v, 0);
    chk("R12 irq low", 32'(irq), 0);
    reg_wr(A_WF, 32'h77);
    reg_rd(A_ISR, v); chk("R12 half set", v, 1);
    chk("R12 irq high", 32'(irq), 1);
    reg_wr(A_ISR, 32'h1);
    reg_rd(A_ISR, v); chk("R12 toggle clear", v, 0);
    chk("R12 irq after clear", 32'(irq), 0);
    reg_wr(A_ISR, 32'h8);
    reg_rd(A_ISR, v); chk("R12 toggle set", v, 8);
    chk("R12 masked", 32'(irq), 0);
    reg_wr(A_IER, 32'h8);
    chk("R12 enabled", 32'(irq), 1);
    reg_wr(A_GIE, 32'h0);
    chk("R12 global off", 32'(irq), 0);
    reg_wr(A_CTRL, 32'h1);
    wait_done("R12 drain");
    reg_rd(A_ISR, v); chk("R12 empty edge", v, 32'hC);

    // R10 soft reset
    reg_wr(A_SZ, 32'h5); reg_wr(A_IER, 32'hF); reg_wr(A_GIE, 32'h8000_0000);
    reg_wr(A_WF, 32'h1); reg_wr(A_WF, 32'h2); reg_wr(A_WF, 32'h3);
    reg_wr(A_CTRL, 32'h8);
    reg_rd(A_CTRL, v); chk("R10 ctrl readback", v, 8);
    reg_rd(A_SZ, v);   chk("R10 size", v, 0);
    reg_rd(A_IER, v);  chk("R10 ier", v, 0);
    reg_rd(A_GIE, v);  chk("R10 gie", v, 0);
    reg_rd(A_WVAC, v); chk("R10 vacancy", v, WD);
    reg_wr(A_WF, 32'h9);
    reg_rd(A_WVAC, v); chk("R10 push dropped", v, WD);
    reg_rd(A_STAT, v); chk("R10 status", v, 32'h1F);
    reg_wr(A_CTRL, 32'h0);
    reg_rd(A_CTRL, v); chk("R10 ctrl released", v, 0);
    reg_rd(A_WVAC, v); chk("R10 vacancy after", v, WD);
    reg_rd(A_ISR, v);  chk("R10 isr", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule